// File: doc/BRIEF.md
# Station address filter

This block decides whether an incoming Ethernet frame is meant for this station. It keeps a small table of 48-bit station addresses and compares each frame's destination address against it. A 16-bit enable mask says which table slots take part in the comparison. Three override modes can widen what is accepted: promiscuous accepts every unicast destination, all-multicast accepts every group destination, and broadcast accepts the all-ones destination.

The table is filled through a word-wide load port that stands in for a descriptor fetch. A start pulse captures a slot count. Then a stream of 16-bit words arrives. Each slot takes a slot-number word and three address words, given least significant byte first. A final word gives the enable mask.

A destination lookup returns accept or reject, plus a broadcast or multicast class flag. A lookup that arrives while a load is in progress is held until the load completes. While the controller is held in reset mode, software-visible ports read back one table slot, chosen by a pointer.

Top module: `station_addr_filter`

## Requirements
- R1: After reset the load port is idle, no lookup result is valid, every slot is disabled, and a lookup with all modes off is rejected.
- R2: A load takes one slot-number word, whose low 4 bits select the slot, then three address words. Address byte 2k is the low byte of word k, and byte 2k+1 is its high byte. Byte 0 is `flt_addr[7:0]`.
- R3: At `load_start`, only the low 5 bits of `load_count` are used. The loader fetches slots until this count reaches zero, counting down by one per slot. When the count is zero, the first word after the start is taken as the enable mask.
- R4: The clock edge that accepts the mask word clears `load_busy` and makes `load_done` high for exactly one cycle.
- R5: Bit i of the enable mask gates slot i. With no mode active, a destination is accepted only if it equals an enabled slot in all 48 bits. A destination held only in a disabled slot is rejected.
- R6: When `mode_promisc` is set, a destination with bit 0 of byte 0 clear (unicast) is accepted, whatever the table holds.
- R7: When `mode_allmulti` is set, a destination with bit 0 of byte 0 set is accepted.
- R8: When `mode_bcast` is set, the destination FF:FF:FF:FF:FF:FF is accepted. When all modes are off, that destination is rejected unless a slot holds it.
- R9: An accepted all-ones destination raises `flt_bcast`. Any other accepted destination with bit 0 of byte 0 set raises `flt_mcast`. A rejected lookup raises neither flag.
- R10: When the loader is idle, `flt_valid` and the result appear in the cycle after `flt_req`. A request made while `load_busy` is high is held. Its result, computed against the newly loaded table, appears one cycle after `load_busy` falls.
- R11: While `ctl_reset_mode` is high, `rd_word0` to `rd_word2` give address words 0 to 2 of the slot chosen by the low 4 bits of `rd_ptr`. While it is low, they read as zero.
- R12: A `load_start` during a load is ignored. A cycle with `load_valid` low consumes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Starts a table load |
| load_count | input | 16 | Slot count; low 5 bits used |
| load_valid | input | 1 | `load_word` carries a word this cycle |
| load_word | input | 16 | Load stream word |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | One-cycle pulse when a load finishes |
| mode_promisc | input | 1 | Accept all unicast destinations |
| mode_allmulti | input | 1 | Accept all multicast destinations |
| mode_bcast | input | 1 | Accept the broadcast destination |
| flt_req | input | 1 | Lookup request |
| flt_addr | input | 48 | Destination address; byte 0 in bits 7:0 |
| flt_valid | output | 1 | Lookup result valid |
| flt_accept | output | 1 | Frame accepted |
| flt_bcast | output | 1 | Accepted frame is broadcast |
| flt_mcast | output | 1 | Accepted frame is multicast |
| ctl_reset_mode | input | 1 | Controller is in reset mode; enables readback |
| rd_ptr | input | 16 | Readback slot pointer; low 4 bits used |
| rd_word0 | output | 16 | Readback address bytes 1:0 |
| rd_word1 | output | 16 | Readback address bytes 3:2 |
| rd_word2 | output | 16 | Readback address bytes 5:4 |

## Verification
The checker assumes that the mode inputs are steady while a lookup is in flight. It also assumes that a held request is not followed by a second request while the load is still running. The directed tests change modes only between lookups, with no request pending, and raise at most one request during any load. The checker further assumes that `load_start` is the only way into the busy state. The tests keep `load_valid` low whenever the loader is idle.

// File: rtl/saf_pkg.sv
package saf_pkg;
   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_INDEX = 2'd1,
      LD_ADDR  = 2'd2,
      LD_MASK  = 2'd3
   } ld_state_e;
endpackage

// File: rtl/saf_loader.sv
module saf_loader #(
   parameter int ENTRIES = 16,
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 48,
   parameter int CNT_W   = 5,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int WORDS  = ADDR_W / WORD_W,
   localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_start,
   input  logic [WORD_W-1:0]  load_count,
   input  logic               load_valid,
   input  logic [WORD_W-1:0]  load_word,
   output logic               busy,
   output logic               done,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [ADDR_W-1:0]  wr_data,
   output logic               mask_we,
   output logic [ENTRIES-1:0] mask_data
);
   import saf_pkg::*;

   ld_state_e           state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [IDX_W-1:0]    idx_q;
   logic [WSEL_W-1:0]   wsel_q;
   logic [ADDR_W-1:0]   buf_q;
   logic                last_word;

   assign last_word = (wsel_q == WSEL_W'(WORDS - 1));
   assign busy      = (state_q != LD_IDLE);
   assign wr_en     = (state_q == LD_ADDR) && load_valid && last_word;
   assign wr_idx    = idx_q;
   assign wr_data   = {load_word, buf_q[ADDR_W-WORD_W-1:0]};
   assign mask_we   = (state_q == LD_MASK) && load_valid;
   assign mask_data = load_word[ENTRIES-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         wsel_q  <= '0;
         buf_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            LD_IDLE: begin
               if (load_start) begin
                  cnt_q   <= load_count[CNT_W-1:0];
                  state_q <= (load_count[CNT_W-1:0] != '0) ? LD_INDEX : LD_MASK;
               end
            end
            LD_INDEX: begin
               if (load_valid) begin
                  idx_q   <= load_word[IDX_W-1:0];
                  wsel_q  <= '0;
                  state_q <= LD_ADDR;
               end
            end
            LD_ADDR: begin
               if (load_valid) begin
                  buf_q[wsel_q*WORD_W +: WORD_W] <= load_word;
                  if (last_word) begin
                     cnt_q   <= cnt_q - 1'b1;
                     state_q <= (cnt_q != CNT_W'(1)) ? LD_INDEX : LD_MASK;
                  end else begin
                     wsel_q <= wsel_q + 1'b1;
                  end
               end
            end
            LD_MASK: begin
               if (load_valid) begin
                  state_q <= LD_IDLE;
                  done    <= 1'b1;
               end
            end
            default: state_q <= LD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/saf_table.sv
module saf_table #(
   parameter int ENTRIES    = 16,
   parameter int WORD_W     = 16,
   parameter int ADDR_W     = 48,
   parameter bit LITTLE_END = 1'b1,
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int WORDS     = ADDR_W / WORD_W,
   localparam int HALF      = WORD_W / 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [ADDR_W-1:0]              wr_data,
   input  logic                           mask_we,
   input  logic [ENTRIES-1:0]             mask_data,
   input  logic                           rd_mode,
   input  logic [WORD_W-1:0]              rd_ptr,
   output logic [ENTRIES-1:0][ADDR_W-1:0] entries,
   output logic [ENTRIES-1:0]             en_mask,
   output logic [ADDR_W-1:0]              rd_words
);
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_entry;
   logic [ADDR_W-1:0] rd_conv;
   logic [IDX_W-1:0]  rd_sel;

   // Word-to-byte order of the stream, chosen at elaboration
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      if (LITTLE_END) begin : g_le
         assign wr_addr[w*WORD_W +: WORD_W] = wr_data[w*WORD_W +: WORD_W];
         assign rd_conv[w*WORD_W +: WORD_W] = rd_entry[w*WORD_W +: WORD_W];
      end else begin : g_be
         assign wr_addr[w*WORD_W +: WORD_W] =
            {wr_data[w*WORD_W +: HALF], wr_data[w*WORD_W+HALF +: HALF]};
         assign rd_conv[w*WORD_W +: WORD_W] =
            {rd_entry[w*WORD_W +: HALF], rd_entry[w*WORD_W+HALF +: HALF]};
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entries[i] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(i))) begin
            entries[i] <= wr_addr;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mask <= '0;
      end else if (mask_we) begin
         en_mask <= mask_data;
      end
   end

   assign rd_sel = rd_ptr[IDX_W-1:0];

   always_comb begin
      rd_entry = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rd_sel == IDX_W'(i)) rd_entry = entries[i];
      end
   end

   assign rd_words = rd_mode ? rd_conv : '0;
endmodule

// File: rtl/saf_match.sv
module saf_match #(
   parameter int ENTRIES = 16,
   parameter int ADDR_W  = 48
) (
   input  logic [ENTRIES-1:0][ADDR_W-1:0] entries,
   input  logic [ENTRIES-1:0]             en_mask,
   input  logic [ADDR_W-1:0]              addr,
   input  logic                           mode_promisc,
   input  logic                           mode_allmulti,
   input  logic                           mode_bcast,
   output logic                           accept,
   output logic                           is_bcast,
   output logic                           is_mcast
);
   logic [ENTRIES-1:0] hit;
   logic               group_bit;
   logic               all_ones;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign hit[i] = en_mask[i] && (entries[i] == addr);
   end

   assign group_bit = addr[0];
   assign all_ones  = &addr;

   assign accept = (mode_promisc  && !group_bit) ||
                   (mode_allmulti &&  group_bit) ||
                   (mode_bcast    &&  all_ones)  ||
                   (|hit);
   assign is_bcast = accept && all_ones;
   assign is_mcast = accept && group_bit && !all_ones;
endmodule

// File: rtl/station_addr_filter.sv
module station_addr_filter #(
   parameter int ENTRIES    = 16,
   parameter int WORD_W     = 16,
   parameter int ADDR_W     = 48,
   parameter int CNT_W      = 5,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic [WORD_W-1:0] load_count,
   input  logic              load_valid,
   input  logic [WORD_W-1:0] load_word,
   output logic              load_busy,
   output logic              load_done,
   input  logic              mode_promisc,
   input  logic              mode_allmulti,
   input  logic              mode_bcast,
   input  logic              flt_req,
   input  logic [ADDR_W-1:0] flt_addr,
   output logic              flt_valid,
   output logic              flt_accept,
   output logic              flt_bcast,
   output logic              flt_mcast,
   input  logic              ctl_reset_mode,
   input  logic [WORD_W-1:0] rd_ptr,
   output logic [WORD_W-1:0] rd_word0,
   output logic [WORD_W-1:0] rd_word1,
   output logic [WORD_W-1:0] rd_word2
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int WORDS = ADDR_W / WORD_W;

   // Elaboration-time parameter checks
   if (WORD_W % 16 != 0) begin : g_bad_word
      $error("WORD_W must be a multiple of 16");
   end
   if (ADDR_W != 3 * WORD_W) begin : g_bad_addr
      $error("ADDR_W must equal three load words");
   end
   if (ENTRIES < 1 || ENTRIES > WORD_W) begin : g_bad_entries
      $error("ENTRIES must fit in one mask word");
   end
   if (CNT_W < 1 || CNT_W > WORD_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   logic                           wr_en;
   logic [IDX_W-1:0]               wr_idx;
   logic [ADDR_W-1:0]              wr_data;
   logic                           mask_we;
   logic [ENTRIES-1:0]             mask_data;
   logic [ENTRIES-1:0][ADDR_W-1:0] entries;
   logic [ENTRIES-1:0]             en_mask;
   logic [ADDR_W-1:0]              rd_words;
   logic [ADDR_W-1:0]              look_addr;
   logic                           m_accept, m_bcast, m_mcast;
   logic                           pend_q;
   logic [ADDR_W-1:0]              hold_q;

   saf_loader #(
      .ENTRIES(ENTRIES), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) i_loader (
      .clk(clk), .rst_n(rst_n),
      .load_start(load_start), .load_count(load_count),
      .load_valid(load_valid), .load_word(load_word),
      .busy(load_busy), .done(load_done),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .mask_we(mask_we), .mask_data(mask_data)
   );

   saf_table #(
      .ENTRIES(ENTRIES), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LITTLE_END(LITTLE_END)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .mask_we(mask_we), .mask_data(mask_data),
      .rd_mode(ctl_reset_mode), .rd_ptr(rd_ptr),
      .entries(entries), .en_mask(en_mask), .rd_words(rd_words)
   );

   assign look_addr = flt_req ? flt_addr : hold_q;

   saf_match #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
   ) i_match (
      .entries(entries), .en_mask(en_mask), .addr(look_addr),
      .mode_promisc(mode_promisc), .mode_allmulti(mode_allmulti),
      .mode_bcast(mode_bcast),
      .accept(m_accept), .is_bcast(m_bcast), .is_mcast(m_mcast)
   );

   // Lookup request: held while loading, resolved one cycle after idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         hold_q     <= '0;
         flt_valid  <= 1'b0;
         flt_accept <= 1'b0;
         flt_bcast  <= 1'b0;
         flt_mcast  <= 1'b0;
      end else begin
         flt_valid  <= 1'b0;
         flt_accept <= 1'b0;
         flt_bcast  <= 1'b0;
         flt_mcast  <= 1'b0;
         if (flt_req && load_busy) begin
            pend_q <= 1'b1;
            hold_q <= flt_addr;
         end else if (!load_busy && (flt_req || pend_q)) begin
            pend_q     <= 1'b0;
            flt_valid  <= 1'b1;
            flt_accept <= m_accept;
            flt_bcast  <= m_bcast;
            flt_mcast  <= m_mcast;
         end
      end
   end

   assign rd_word0 = rd_words[0*WORD_W +: WORD_W];
   assign rd_word1 = rd_words[1*WORD_W +: WORD_W];
   assign rd_word2 = rd_words[(WORDS-1)*WORD_W +: WORD_W];
endmodule

// File: rtl/saf_checker.sv
module saf_checker (
   input logic clk,
   input logic rst_n,
   input logic load_start,
   input logic load_busy,
   input logic load_done,
   input logic flt_valid,
   input logic flt_accept,
   input logic flt_bcast,
   input logic flt_mcast
);
   // R4: completion pulse only as the load leaves busy
   assert_done_ends_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> (!load_busy && $past(load_busy)));

   // R12: busy is entered only through a start pulse
   assert_busy_from_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (load_busy && !$past(load_busy)) |-> $past(load_start));

   // R10: a result is produced only from an idle loader
   assert_result_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |-> $past(!load_busy));

   // R9: rejected lookups carry no class flag
   assert_reject_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !flt_accept) |-> (!flt_bcast && !flt_mcast));

   // R9: class flags are exclusive and only with a valid result
   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flt_bcast, flt_mcast}) && ((flt_bcast || flt_mcast) -> flt_valid));
endmodule

bind station_addr_filter saf_checker i_chk (
   .clk(clk), .rst_n(rst_n), .load_start(load_start),
   .load_busy(load_busy), .load_done(load_done),
   .flt_valid(flt_valid), .flt_accept(flt_accept),
   .flt_bcast(flt_bcast), .flt_mcast(flt_mcast)
);

// File: tb/test_station_addr_filter.sv
module test_station_addr_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        load_start, load_valid;
   logic [15:0] load_count, load_word;
   logic        load_busy, load_done;
   logic        mode_promisc, mode_allmulti, mode_bcast;
   logic        flt_req;
   logic [47:0] flt_addr;
   logic        flt_valid, flt_accept, flt_bcast, flt_mcast;
   logic        ctl_reset_mode;
   logic [15:0] rd_ptr, rd_word0, rd_word1, rd_word2;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   localparam logic [47:0] ADDR_A = 48'h5544_3322_1100;  // unicast
   localparam logic [47:0] ADDR_B = 48'h0605_0403_0201;  // multicast
   localparam logic [47:0] ADDR_C = 48'hC5C4_C3C2_C1C0;  // unicast
   localparam logic [47:0] ADDR_D = 48'h0A0B_0C0D_0E10;  // unicast
   localparam logic [47:0] ADDR_U = 48'h0000_0000_00AA;  // unicast, not loaded
   localparam logic [47:0] ADDR_M = 48'h0000_0000_0003;  // multicast, not loaded
   localparam logic [47:0] ADDR_F = 48'hFFFF_FFFF_FFFF;  // broadcast

   always #(CLK_PERIOD/2) clk = ~clk;

   station_addr_filter i_station_addr_filter (
      .clk(clk), .rst_n(rst_n),
      .load_start(load_start), .load_count(load_count),
      .load_valid(load_valid), .load_word(load_word),
      .load_busy(load_busy), .load_done(load_done),
      .mode_promisc(mode_promisc), .mode_allmulti(mode_allmulti),
      .mode_bcast(mode_bcast),
      .flt_req(flt_req), .flt_addr(flt_addr),
      .flt_valid(flt_valid), .flt_accept(flt_accept),
      .flt_bcast(flt_bcast), .flt_mcast(flt_mcast),
      .ctl_reset_mode(ctl_reset_mode), .rd_ptr(rd_ptr),
      .rd_word0(rd_word0), .rd_word1(rd_word1), .rd_word2(rd_word2)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // All drive tasks are entered and left at a falling edge
   task automatic start_load(input logic [15:0] cnt);
      load_start = 1'b1;
      load_count = cnt;
      @(negedge clk);
      load_start = 1'b0;
   endtask

   task automatic send(input logic [15:0] w);
      load_valid = 1'b1;
      load_word  = w;
      @(negedge clk);
      load_valid = 1'b0;
   endtask

   task automatic send_slot(input logic [15:0] idx, input logic [47:0] a);
      send(idx);
      send(a[15:0]);
      send(a[31:16]);
      send(a[47:32]);
   endtask

   task automatic send_mask_and_check(input logic [15:0] m, input string tag);
      send(m);
      chk({tag, " done pulse"}, {62'd0, load_busy, load_done}, 64'h1);
      @(negedge clk);
      chk({tag, " done one cycle"}, {62'd0, load_busy, load_done}, 64'h0);
   endtask

   task automatic lookup(input logic [47:0] a, input logic acc, input logic b,
                         input logic m, input string tag);
      flt_req  = 1'b1;
      flt_addr = a;
      @(negedge clk);
      flt_req = 1'b0;
      chk(tag, {60'd0, flt_valid, flt_accept, flt_bcast, flt_mcast},
          {60'd0, 1'b1, acc, b, m});
   endtask

   task automatic set_modes(input logic p, input logic am, input logic bc);
      mode_promisc  = p;
      mode_allmulti = am;
      mode_bcast    = bc;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {61'd0, load_busy, load_done, flt_valid}, 64'h0);
      ctl_reset_mode = 1'b1;
      rd_ptr = 16'h0000;
      #1;
      chk("R1 slot0 cleared", {rd_word2, rd_word1, rd_word0}, 64'h0);
      ctl_reset_mode = 1'b0;
      lookup(ADDR_A, 1'b0, 1'b0, 1'b0, "R1 empty table rejects");
   endtask

   task automatic t_load_two();
      start_load(16'h0002);
      chk("R3 busy after start", {63'd0, load_busy}, 64'h1);
      send_slot(16'h0003, ADDR_A);
      chk("R3 still busy after first slot", {63'd0, load_busy}, 64'h1);
      send_slot(16'h0007, ADDR_B);
      send_mask_and_check(16'h0008, "R4 two slot load");
      lookup(ADDR_A, 1'b1, 1'b0, 1'b0, "R5 enabled slot matches");
      lookup(ADDR_B, 1'b0, 1'b0, 1'b0, "R5 disabled slot rejected");
      lookup(48'h5544_3322_1000, 1'b0, 1'b0, 1'b0, "R5 one bit off rejected");
      ctl_reset_mode = 1'b1;
      rd_ptr = 16'hFFF3;
      #1;
      chk("R2 R11 readback slot 3", {rd_word2, rd_word1, rd_word0}, {16'd0, ADDR_A});
      rd_ptr = 16'h0007;
      #1;
      chk("R2 R11 readback slot 7", {rd_word2, rd_word1, rd_word0}, {16'd0, ADDR_B});
      ctl_reset_mode = 1'b0;
      #1;
      chk("R11 readback blocked outside reset", {rd_word2, rd_word1, rd_word0}, 64'h0);
      @(negedge clk);
   endtask

   task automatic t_count_zero();
      start_load(16'h0020);
      chk("R3 count low bits zero busy", {63'd0, load_busy}, 64'h1);
      send_mask_and_check(16'h0088, "R3 mask taken first");
      lookup(ADDR_B, 1'b1, 1'b0, 1'b1, "R9 R5 multicast slot accepted");
      lookup(ADDR_A, 1'b1, 1'b0, 1'b0, "R3 slots kept across mask reload");
   endtask

   task automatic t_modes();
      set_modes(1'b0, 1'b0, 1'b0);
      lookup(ADDR_U, 1'b0, 1'b0, 1'b0, "R6 unicast rejected modes off");
      lookup(ADDR_M, 1'b0, 1'b0, 1'b0, "R7 multicast rejected modes off");
      lookup(ADDR_F, 1'b0, 1'b0, 1'b0, "R8 broadcast rejected modes off");
      set_modes(1'b1, 1'b0, 1'b0);
      lookup(ADDR_U, 1'b1, 1'b0, 1'b0, "R6 promiscuous accepts unicast");
      lookup(ADDR_M, 1'b0, 1'b0, 1'b0, "R6 promiscuous ignores multicast");
      set_modes(1'b0, 1'b1, 1'b0);
      lookup(ADDR_M, 1'b1, 1'b0, 1'b1, "R7 all-multicast accepts group");
      lookup(ADDR_F, 1'b1, 1'b1, 1'b0, "R9 broadcast flag under all-multicast");
      lookup(ADDR_U, 1'b0, 1'b0, 1'b0, "R7 all-multicast ignores unicast");
      set_modes(1'b0, 1'b0, 1'b1);
      lookup(ADDR_F, 1'b1, 1'b1, 1'b0, "R8 broadcast mode accepts all ones");
      lookup(ADDR_M, 1'b0, 1'b0, 1'b0, "R8 broadcast mode ignores multicast");
      set_modes(1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_hold();
      start_load(16'h0001);
      send(16'h0005);
      flt_req  = 1'b1;
      flt_addr = ADDR_C;
      @(negedge clk);
      flt_req = 1'b0;
      chk("R10 no result during load", {63'd0, flt_valid}, 64'h0);
      send(ADDR_C[15:0]);
      send(ADDR_C[31:16]);
      send(ADDR_C[47:32]);
      send(16'h0020);
      chk("R10 held until busy falls", {62'd0, load_busy, flt_valid}, 64'h0);
      @(negedge clk);
      chk("R10 held request uses new table",
          {60'd0, flt_valid, flt_accept, flt_bcast, flt_mcast}, 64'hC);
      @(negedge clk);
      chk("R10 single result", {63'd0, flt_valid}, 64'h0);
   endtask

   task automatic t_ignore();
      start_load(16'h0001);
      load_start = 1'b1;
      load_count = 16'h0000;
      @(negedge clk);
      load_start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 restart and idle cycles ignored", {62'd0, load_busy, load_done}, 64'h2);
      send_slot(16'h0009, ADDR_D);
      chk("R12 slot words all consumed", {62'd0, load_busy, load_done}, 64'h2);
      send_mask_and_check(16'h0200, "R12 R4 load completes");
      lookup(ADDR_D, 1'b1, 1'b0, 1'b0, "R12 slot 9 accepted");
      lookup(ADDR_C, 1'b0, 1'b0, 1'b0, "R5 slot 5 now disabled");
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      rst_n = 1'b0;
      load_start = 1'b0; load_count = '0; load_valid = 1'b0; load_word = '0;
      mode_promisc = 1'b0; mode_allmulti = 1'b0; mode_bcast = 1'b0;
      flt_req = 1'b0; flt_addr = '0;
      ctl_reset_mode = 1'b0; rd_ptr = '0;
      @(negedge clk);
      t_reset();
      t_load_two();
      t_count_zero();
      t_modes();
      t_hold();
      t_ignore();
      summary();
   end
endmodule